// File: doc/BRIEF.md
# Receive Descriptor Ring Frame Writer

This block takes one received frame at a time from a byte stream and spreads it over memory buffers. A circular ring of 8-byte descriptors in memory describes those buffers. A frame is offered with a one-cycle request that carries its length, and the block answers one cycle later with an accept pulse or a drop pulse. Once it accepts a frame, it walks the ring from its current pointer. For each descriptor it reads the descriptor, copies bytes into that descriptor's buffer up to the per-buffer byte limit, and writes back the descriptor's flags and the length it filled. Four zero bytes stand in for the CRC and follow the payload. They count toward the frame size. When enabled, a zero-filled control block comes before the payload.

When the walk meets a descriptor that software still owns, or comes back round to the descriptor it started from before the frame is complete, the block halts. It holds the rest of the frame by back-pressuring the byte stream until a restart pulse. It then continues the same frame at the descriptor after the one where it stopped. Buffer-done and frame-done pulses are raised for descriptors that request an interrupt. A sticky status bit records that a frame-done event has happened.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame request that arrives while an earlier accepted frame is not yet complete (including while halted) gets a `frm_drop` pulse in the next cycle and is otherwise ignored.
- R2: A frame request is dropped (pulse on `frm_drop` the next cycle) when `rx_en` is low or `rx_stop` is high. An accepted request gives a pulse on `frm_acc` the next cycle.
- R3: With `short_rej` high, a request whose `frame_len` is below 60 is dropped. With `short_rej` low, such a frame is accepted.
- R4: Descriptor layout: word at offset 0 holds flags in bits 31:16 and the filled length in bits 15:0; the word at offset 4 holds the buffer byte address. Memory is big-endian: byte offset k of a word is bits 31-8k down to 24-8k and is enabled by `mem_be[3-k]`. Flag bits: 15 empty, 14 first, 13 wrap, 12 interrupt, 11 last, 5 length violation, 3 short. Only descriptors with the empty bit set receive data. Each takes at most `max_buf_len` bytes. The empty bit is cleared when at least one byte was written.
- R5: Four zero bytes follow the payload, and the frame size used for the flag checks is `frame_len` + 4.
- R6: When `parse_depth` is nonzero, 8 + `align_pad` zero bytes are written before the payload. They are counted against the buffer limit but not in the frame size.
- R7: The first descriptor that receives data for a frame gets the first flag. No later descriptor of that frame gets it, including after a resume.
- R8: On the descriptor that completes the frame, flag bits 10:0 are cleared and the last flag is set. Bit 5 is set if size ≥ `max_frame`, and bit 3 is set if size < 64.
- R9: After each descriptor the pointer moves to the ring base if the wrap flag was set, or else to the next 8-byte slot. The walk ends at frame completion, at a descriptor without the empty bit (the pointer still moves past it), or on returning to the descriptor the walk started from.
- R10: If the walk ends with bytes left, `ring_halted` is set and `in_ready` stays low. A `restart` pulse clears the halt and continues the same frame from the current pointer.
- R11: A completing descriptor with its interrupt flag gives a `frame_done` pulse and sets the sticky `frame_stat`. A non-completing descriptor with its interrupt flag gives a `buf_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rx_stop | input | 1 | Stop accepting new frames |
| short_rej | input | 1 | Drop frames shorter than 60 bytes |
| parse_depth | input | 2 | Nonzero enables the leading control block |
| align_pad | input | 5 | Extra control-block bytes beyond 8 |
| max_buf_len | input | 16 | Byte limit per buffer |
| max_frame | input | 16 | Length-violation threshold |
| restart | input | 1 | Clear halt and resume the pending frame |
| frame_req | input | 1 | One-cycle frame offer |
| frame_len | input | 16 | Payload length of the offered frame |
| frm_acc | output | 1 | Frame accepted pulse |
| frm_drop | output | 1 | Frame refused pulse |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 is byte offset 0 |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| ring_halted | output | 1 | Ring halted with frame bytes pending |
| buf_done | output | 1 | Buffer-done event pulse |
| frame_done | output | 1 | Frame-done event pulse |
| frame_stat | output | 1 | Sticky frame-done status |

## Verification
The assertions assume a memory that returns read data exactly one cycle after a read request. They also assume a byte source that offers no more payload bytes than the accepted `frame_len`, with `frame_req` pulses only between frames or as deliberate refusal probes. The bench's memory model has a fixed one-cycle read latency, and it queues exactly `frame_len` bytes per accepted frame. It inserts periodic gaps in `in_valid`, and it changes the configuration inputs only while no frame is in flight. Descriptors are re-armed by the bench only between walks.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter logic [31:0] RING_BASE = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_stop,
  input  logic          short_rej,
  input  logic [1:0]    parse_depth,
  input  logic [4:0]    align_pad,
  input  logic [LW-1:0] max_buf_len,
  input  logic [LW-1:0] max_frame,
  input  logic          restart,
  input  logic          frame_req,
  input  logic [LW-1:0] frame_len,
  output logic          frm_acc,
  output logic          frm_drop,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ring_halted,
  output logic          buf_done,
  output logic          frame_done,
  output logic          frame_stat
);
  localparam int DESC_BYTES = 8;
  localparam int SW = LW + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD2, S_FILL, S_WB} st_t;
  st_t st;

  logic [AW-1:0] ptr, start_ptr, d_buf;
  logic [15:0]   d_flags, new_flags;
  logic [LW-1:0] cnt;
  logic [SW-1:0] left, frm_size;
  logic [5:0]    fcb_left;
  logic          first, pending;

  logic [5:0]    fcb_len;
  logic          ok, take, fill_end, need_byte, wr_go;
  logic [AW-1:0] byte_addr, next_ptr;
  logic [7:0]    byte_val;
  logic          unused_len;

  assign unused_len = ^mem_rdata[15:0];
  assign fcb_len   = (parse_depth != 2'd0) ? 6'd8 + {1'b0, align_pad} : 6'd0;
  assign ok        = rx_en && !rx_stop && !ring_halted && !pending && st == S_IDLE &&
                     !(short_rej && frame_len < LW'(60));
  assign take      = frame_req && ok;
  assign fill_end  = (left == '0) || (cnt >= max_buf_len);
  assign need_byte = st == S_FILL && !fill_end && fcb_left == '0 && left > SW'(4);
  assign in_ready  = need_byte;
  assign wr_go     = st == S_FILL && !fill_end && (!need_byte || in_valid);
  assign byte_val  = need_byte ? in_data : 8'h00;
  assign byte_addr = d_buf + AW'(cnt);
  assign next_ptr  = d_flags[13] ? AW'(RING_BASE) : ptr + AW'(DESC_BYTES);

  always_comb begin
    new_flags = d_flags;
    if (cnt != '0) new_flags[15] = 1'b0;
    if (first)     new_flags[14] = 1'b1;
    if (left == '0) begin
      new_flags[10:0] = '0;
      new_flags[11]   = 1'b1;
      new_flags[5]    = frm_size >= {1'b0, max_frame};
      new_flags[3]    = frm_size < SW'(64);
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_be    = 4'b0000;
    mem_wdata = '0;
    case (st)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = ptr + AW'(4); end
      S_FILL: begin
        mem_req   = wr_go;
        mem_we    = wr_go;
        mem_addr  = {byte_addr[AW-1:2], 2'b00};
        mem_be    = 4'b1000 >> byte_addr[1:0];
        mem_wdata = {4{byte_val}};
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'b1111;
        mem_wdata = {new_flags, 16'(cnt)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= AW'(RING_BASE);
      start_ptr <= AW'(RING_BASE);
      d_buf <= '0;
      d_flags <= '0;
      cnt <= '0;
      left <= '0;
      frm_size <= '0;
      fcb_left <= '0;
      first <= 1'b0;
      pending <= 1'b0;
      ring_halted <= 1'b0;
      frm_acc <= 1'b0;
      frm_drop <= 1'b0;
      buf_done <= 1'b0;
      frame_done <= 1'b0;
      frame_stat <= 1'b0;
    end else begin
      frm_acc    <= take;
      frm_drop   <= frame_req && !take;
      buf_done   <= 1'b0;
      frame_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ring_halted && restart) begin
            ring_halted <= 1'b0;
            start_ptr <= ptr;
            st <= S_RD0;
          end else if (take) begin
            pending   <= 1'b1;
            left      <= {1'b0, frame_len} + SW'(4) + SW'(fcb_len);
            frm_size  <= {1'b0, frame_len} + SW'(4);
            fcb_left  <= fcb_len;
            first     <= 1'b1;
            start_ptr <= ptr;
            st        <= S_RD0;
          end
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin
          d_flags <= mem_rdata[31:16];
          st <= S_RD2;
        end
        S_RD2: begin
          d_buf <= mem_rdata[AW-1:0];
          if (!d_flags[15]) begin
            ptr <= next_ptr;
            ring_halted <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= '0;
            st <= S_FILL;
          end
        end
        S_FILL: begin
          if (fill_end) st <= S_WB;
          else if (wr_go) begin
            cnt  <= cnt + LW'(1);
            left <= left - SW'(1);
            if (fcb_left != '0) fcb_left <= fcb_left - 6'd1;
          end
        end
        S_WB: begin
          ptr   <= next_ptr;
          first <= 1'b0;
          if (left == '0) begin
            pending <= 1'b0;
            st <= S_IDLE;
            if (d_flags[12]) begin
              frame_done <= 1'b1;
              frame_stat <= 1'b1;
            end
          end else begin
            if (d_flags[12]) buf_done <= 1'b1;
            if (next_ptr == start_ptr) begin
              ring_halted <= 1'b1;
              st <= S_IDLE;
            end else st <= S_RD0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req && pending |=> frm_drop && !frm_acc);
  a_r2_rx_off_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req && (!rx_en || rx_stop) |=> frm_drop);
  a_r3_short_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req && short_rej && frame_len < LW'(60) |=> frm_drop);
  a_r4_byte_goes_to_memory: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |-> mem_req && mem_we && $onehot0(mem_be));
  a_r10_halt_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    ring_halted |-> !in_ready);
  a_r11_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_stat && !pending && !ring_halted);
  a_r11_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_stat) |-> frame_stat);
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_en = 1, rx_stop = 0, short_rej = 0, restart = 0, frame_req = 0;
  logic [1:0] parse_depth = 0;
  logic [4:0] align_pad = 0;
  logic [15:0] max_buf_len = 64, max_frame = 1536, frame_len = 0;
  logic frm_acc, frm_drop, in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] mem_be;
  logic ring_halted, buf_done, frame_done, frame_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_stop(rx_stop), .short_rej(short_rej),
    .parse_depth(parse_depth), .align_pad(align_pad), .max_buf_len(max_buf_len),
    .max_frame(max_frame), .restart(restart), .frame_req(frame_req), .frame_len(frame_len),
    .frm_acc(frm_acc), .frm_drop(frm_drop), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ring_halted(ring_halted), .buf_done(buf_done), .frame_done(frame_done),
    .frame_stat(frame_stat));

  logic [7:0] dmem [0:4095];
  logic [7:0] emem [0:4095];
  int checks = 0, fails = 0, cyc = 0;
  int fd_cnt = 0, bd_cnt = 0;
  byte unsigned feed_q[$];
  logic f_v = 0, f_r = 0;

  int m_ptr = 0, m_left = 0, m_pos = 0, m_size = 0, m_fd = 0, m_bd = 0;
  bit m_first = 0, m_halt = 0, m_pend = 0, settled = 0;
  byte unsigned m_stream[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[3-k]) dmem[(mem_addr & 32'hFFC) + k] = mem_wdata[31-8*k -: 8];
      end else begin
        mem_rdata <= {dmem[mem_addr[11:0]], dmem[mem_addr[11:0]+1],
                      dmem[mem_addr[11:0]+2], dmem[mem_addr[11:0]+3]};
      end
    end
  end

  always @(negedge clk) begin
    if (f_v && f_r) void'(feed_q.pop_front());
    in_valid = feed_q.size() > 0 && (cyc % 5 != 4);
    in_data  = in_valid ? feed_q[0] : 8'h00;
    f_v = in_valid;
    f_r = in_ready;
    if (frame_done) fd_cnt++;
    if (buf_done) bd_cnt++;
    if (settled) begin
      chk(ring_halted == m_halt, "R10", "per-clock halt state", ring_halted, m_halt);
      chk(frame_stat == (m_fd > 0), "R11", "per-clock status bit", frame_stat, m_fd > 0);
    end
  end

  task automatic put_word(int a, logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      dmem[a+k] = w[31-8*k -: 8];
      emem[a+k] = w[31-8*k -: 8];
    end
  endtask

  task automatic arm(int i, logic [15:0] fl);
    put_word(i*8, {fl, 16'h0});
    put_word(i*8 + 4, 32'h100 + i*32'h100);
  endtask

  task automatic arm_all();
    for (int i = 0; i < 4; i++) arm(i, 16'h9000 | (i == 3 ? 16'h2000 : 16'h0));
  endtask

  task automatic m_walk();
    int st, a, bp, nx, cnt;
    logic [15:0] fl, nf;
    st = m_ptr;
    forever begin
      a  = m_ptr;
      fl = {emem[a], emem[a+1]};
      bp = {emem[a+4], emem[a+5], emem[a+6], emem[a+7]};
      nx = fl[13] ? 0 : a + 8;
      if (!fl[15]) begin m_ptr = nx; m_halt = 1; return; end
      cnt = 0;
      while (m_left > 0 && cnt < int'(max_buf_len)) begin
        emem[bp+cnt] = m_stream[m_pos];
        m_pos++; cnt++; m_left--;
      end
      nf = fl;
      if (cnt > 0) nf[15] = 0;
      if (m_first) nf[14] = 1;
      m_first = 0;
      if (m_left == 0) begin
        nf[10:0] = 0; nf[11] = 1;
        nf[5] = m_size >= int'(max_frame);
        nf[3] = m_size < 64;
        if (fl[12]) m_fd++;
      end else if (fl[12]) m_bd++;
      emem[a] = nf[15:8]; emem[a+1] = nf[7:0];
      emem[a+2] = 8'(cnt >> 8); emem[a+3] = 8'(cnt);
      m_ptr = nx;
      if (m_left == 0) begin m_pend = 0; return; end
      if (m_ptr == st) begin m_halt = 1; return; end
    end
  endtask

  task automatic settle_and_check(string req);
    int n = 0;
    settled = 0;
    while (n < 5000 && !(m_halt ? ring_halted : (fd_cnt == m_fd && bd_cnt == m_bd))) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    settled = 1;
    begin
      int bad = 0, first_bad = -1;
      for (int a = 0; a < 2048; a++)
        if (dmem[a] !== emem[a]) begin bad++; if (first_bad < 0) first_bad = a; end
      chk(bad == 0, req, $sformatf("memory image (first bad addr %0d, byte)", first_bad),
          first_bad < 0 ? 0 : int'(dmem[first_bad]), first_bad < 0 ? 0 : int'(emem[first_bad]));
    end
    chk(fd_cnt == m_fd, "R11", "frame_done count", fd_cnt, m_fd);
    chk(bd_cnt == m_bd, "R11", "buf_done count", bd_cnt, m_bd);
    chk(ring_halted == m_halt, "R10", "halt state", ring_halted, m_halt);
  endtask

  task automatic offer(int len, int seed, string req);
    bit exp_ok;
    int fcb;
    exp_ok = rx_en && !rx_stop && !m_halt && !m_pend && !(short_rej && len < 60);
    @(negedge clk);
    frame_len = 16'(len); frame_req = 1;
    @(negedge clk);
    frame_req = 0;
    chk(frm_acc == exp_ok, req, "accept pulse", frm_acc, exp_ok);
    chk(frm_drop == !exp_ok, req, "drop pulse", frm_drop, !exp_ok);
    if (exp_ok) begin
      fcb = parse_depth != 0 ? 8 + align_pad : 0;
      m_stream.delete();
      for (int i = 0; i < fcb; i++) m_stream.push_back(0);
      for (int i = 0; i < len; i++) begin
        m_stream.push_back(8'(seed + i*7));
        feed_q.push_back(8'(seed + i*7));
      end
      for (int i = 0; i < 4; i++) m_stream.push_back(0);
      m_left = fcb + len + 4; m_pos = 0; m_first = 1; m_size = len + 4; m_pend = 1;
      m_walk();
      settle_and_check(req);
    end
  endtask

  task automatic do_restart(string req);
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    m_halt = 0;
    m_walk();
    settle_and_check(req);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) begin dmem[a] = 0; emem[a] = 0; end
    arm_all();
    repeat (3) @(negedge clk);
    chk(ring_halted == 0 && in_ready == 0 && frame_done == 0 && mem_req == 0 && frm_acc == 0,
        "R10", "reset state quiet", {ring_halted, in_ready, frame_done, mem_req, frm_acc}, 0);
    rst_n = 1;
    settled = 1;
    @(negedge clk);

    offer(100, 3, "R4");
    arm_all();
    offer(50, 11, "R8");
    arm_all();
    max_frame = 100;
    offer(96, 21, "R9");
    max_frame = 1536;
    arm_all();
    parse_depth = 1; align_pad = 3;
    offer(70, 40, "R6");
    parse_depth = 0; align_pad = 0;

    short_rej = 1; offer(50, 5, "R3"); offer(60, 6, "R3");
    short_rej = 0;
    rx_en = 0; offer(80, 7, "R2"); rx_en = 1;
    rx_stop = 1; offer(80, 8, "R2"); rx_stop = 0;

    arm_all();
    arm(m_ptr == 24 ? 0 : (m_ptr/8 + 1) % 4, 16'h1000);
    offer(100, 50, "R10");
    repeat (20) begin
      @(negedge clk);
      chk(in_ready == 0 && feed_q.size() > 0, "R10", "input held while halted", in_ready, 0);
    end
    offer(30, 9, "R1");
    do_restart("R7");

    arm_all();
    max_buf_len = 16;
    offer(100, 77, "R9");
    arm_all();
    do_restart("R5");
    max_buf_len = 64;
    chk(feed_q.size() == 0, "R5", "all payload consumed", feed_q.size(), 0);

    settled = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule